// File: doc/BRIEF.md
# Operand-Tracking Computation Unit

This block supervises a single arithmetic operation from the moment it is issued until its result has been accepted for write-back. Outside dependency logic can therefore see when each operation starts and when it ends. An issuer presents an opcode, modifier flags and a per-port read mask together with a one-cycle issue pulse. The unit latches these values and raises busy on the next cycle. Busy then stays high until the result has been taken.

Each of the two source operands has its own request/go handshake. The unit raises a read request, and the register side answers with a go pulse that carries the operand value. A port is not requested at all when its operand is forced to zero, replaced by an immediate, or masked off. Once every required operand is in hand, a small 16-bit ALU computes the result. The unit registers that result and offers it through a write request. A single write-go pulse then retires the operation.

Top module: `cu_unit`

## Requirements
- R1: While reset is asserted, busy_o, both rd_rel_o bits and wr_rel_o are low.
- R2: busy_o is low in the cycle issue_i is accepted and high from the next cycle onward. It never rises without an issue. An issue_i pulse that arrives while busy_o is high is ignored and does not change the result.
- R3: In the cycle after issue, rd_rel_o[p] is high for every port p that is not skipped. It stays high through any number of stall cycles until rd_go_i[p] is seen.
- R4: rd_rel_o[p] falls in the cycle after its rd_go_i[p] pulse, and it does not rise again during that operation. rd_go_i may be driven in the same cycle that the request first appears.
- R5: Port 0 (operand A) is skipped when zero_a_i is set. Port 1 (operand B) is skipped when imm_ok_i is set. Port p is skipped when rd_mask_i[p] is set.
- R6: A skipped A operand is 0. A skipped B operand is imm_i when imm_ok_i is set and 0 otherwise. A read operand is the src value present during its go cycle.
- R7: Opcode value 1 selects add. The add result is A+B, or (~A)+B when inv_a_i is set, truncated to 16 bits. For example, 5 and 2 with inversion give 65532.
- R8: Any other opcode value gives A−B modulo 2^16.
- R9: wr_rel_o rises two cycles after the last operand's go cycle, or two cycles after issue when no port is read. data_o holds the result and stays stable while wr_rel_o is high.
- R10: A one-cycle wr_go_i while wr_rel_o is high clears wr_rel_o and busy_o in the next cycle. Opcode and flag inputs that change after the issue cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | 4 | Opcode (1 = add, others = subtract) |
| inv_a_i | input | 1 | Invert operand A for add |
| zero_a_i | input | 1 | Treat operand A as zero, no read |
| imm_ok_i | input | 1 | Take operand B from immediate, no read |
| imm_i | input | 16 | Immediate value |
| rd_mask_i | input | 2 | Per-port read suppression (bit 0 = A, bit 1 = B) |
| src_a_i | input | 16 | Operand A data, valid with rd_go_i[0] |
| src_b_i | input | 16 | Operand B data, valid with rd_go_i[1] |
| rd_rel_o | output | 2 | Per-port read request |
| rd_go_i | input | 2 | Per-port read grant |
| wr_rel_o | output | 1 | Result write request |
| wr_go_i | input | 1 | Result write grant |
| data_o | output | 16 | Result value |
| busy_o | output | 1 | Operation in flight |

## Verification
The bench uses directed operations to pin down specific behaviours. Plain add, inverted add and subtract show that the opcode and invert decode are right. Zero, immediate and mask combinations show that the operand substitution is right and that no request is raised for a skipped port. Go delays of zero and three cycles separate a same-cycle grant from a stall. A seeded random sequence then varies the opcode, the flags, the mask, the per-port go delay and the write delay. It also injects stray issue pulses while busy and changes the inputs after issue. These show that the result depends only on the values latched at issue and on the operands captured during each go.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } cu_state_e;

  localparam int unsigned NUM_RD = 2;
endpackage

// File: rtl/cu_read_port.sv
module cu_read_port #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          skip_i,
  input  logic [DW-1:0] subst_i,
  input  logic          go_i,
  input  logic [DW-1:0] src_i,
  output logic          rel_o,
  output logic [DW-1:0] opnd_o
);
  logic          rel_q, rel_d;
  logic [DW-1:0] opnd_q, opnd_d;
  logic          opnd_en;

  always_comb begin
    rel_d   = rel_q;
    opnd_d  = opnd_q;
    opnd_en = 1'b0;
    if (start_i) begin
      rel_d   = ~skip_i;
      opnd_d  = subst_i;
      opnd_en = 1'b1;
    end else if (rel_q && go_i) begin
      rel_d   = 1'b0;
      opnd_d  = src_i;
      opnd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      opnd_q <= '0;
    end else begin
      rel_q <= rel_d;
      if (opnd_en) opnd_q <= opnd_d;
    end
  end

  assign rel_o  = rel_q;
  assign opnd_o = opnd_q;

  AST_REL_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !skip_i |=> rel_o); // R3
  AST_REL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && skip_i |=> !rel_o); // R5
  AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o && !go_i |=> rel_o); // R3
  AST_REL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o && go_i |=> !rel_o && opnd_o == $past(src_i)); // R4
  AST_NO_RERISE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !rel_o |=> !rel_o); // R4
endmodule

// File: rtl/cu_alu.sv
module cu_alu #(
  parameter int unsigned DW  = 16,
  parameter int unsigned OPW = 4,
  parameter logic [OPW-1:0] ADD_OP = 1
) (
  input  logic [OPW-1:0] op_i,
  input  logic           inv_a_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  res_o
);
  logic [DW-1:0] a_eff;

  always_comb begin
    a_eff = inv_a_i ? ~a_i : a_i;
    if (op_i == ADD_OP) res_o = a_eff + b_i;
    else                res_o = a_i - b_i;
  end
endmodule

// File: rtl/cu_unit.sv
module cu_unit #(
  parameter int unsigned DW  = 16,
  parameter int unsigned OPW = 4,
  parameter logic [OPW-1:0] ADD_OP = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_i,
  input  logic [OPW-1:0] op_i,
  input  logic           inv_a_i,
  input  logic           zero_a_i,
  input  logic           imm_ok_i,
  input  logic [DW-1:0]  imm_i,
  input  logic [1:0]     rd_mask_i,
  input  logic [DW-1:0]  src_a_i,
  input  logic [DW-1:0]  src_b_i,
  output logic [1:0]     rd_rel_o,
  input  logic [1:0]     rd_go_i,
  output logic           wr_rel_o,
  input  logic           wr_go_i,
  output logic [DW-1:0]  data_o,
  output logic           busy_o
);
  import cu_pkg::*;

  localparam int unsigned NP = NUM_RD;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cu_state_e      state_q, state_d;
  logic [OPW-1:0] op_q;
  logic           inv_q;
  logic [DW-1:0]  res_q;
  logic           start, res_en;
  logic [DW-1:0]  alu_res;

  logic [NP-1:0]  skip;
  logic [DW-1:0]  subst [NP];
  logic [DW-1:0]  srcs  [NP];
  logic [DW-1:0]  opnd  [NP];
  logic [NP-1:0]  rel;

  assign start = issue_i && (state_q == ST_IDLE);

  assign skip[0]  = zero_a_i | rd_mask_i[0];
  assign subst[0] = '0;
  assign srcs[0]  = src_a_i;
  assign skip[1]  = imm_ok_i | rd_mask_i[1];
  assign subst[1] = imm_ok_i ? imm_i : '0;
  assign srcs[1]  = src_b_i;

  for (genvar p = 0; p < NP; p++) begin : g_port
    cu_read_port #(.DW(DW)) u_port (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .start_i (start),
      .skip_i  (skip[p]),
      .subst_i (subst[p]),
      .go_i    (rd_go_i[p]),
      .src_i   (srcs[p]),
      .rel_o   (rel[p]),
      .opnd_o  (opnd[p])
    );
  end

  cu_alu #(.DW(DW), .OPW(OPW), .ADD_OP(ADD_OP)) u_alu (
    .op_i    (op_q),
    .inv_a_i (inv_q),
    .a_i     (opnd[0]),
    .b_i     (opnd[1]),
    .res_o   (alu_res)
  );

  always_comb begin
    state_d = state_q;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (issue_i) state_d = ST_READ;
      ST_READ:  if (rel == '0) begin
                  state_d = ST_WRITE;
                  res_en  = 1'b1;
                end
      ST_WRITE: if (wr_go_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      inv_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        op_q  <= op_i;
        inv_q <= inv_a_i;
      end
      if (res_en) res_q <= alu_res;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign wr_rel_o = (state_q == ST_WRITE);
  assign rd_rel_o = rel;
  assign data_o   = res_q;

  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue_i && !busy_o |=> busy_o); // R2
  AST_NO_SELF_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    !issue_i && !busy_o |=> !busy_o); // R2
  AST_REL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_rel_o != '0 |-> busy_o && !wr_rel_o); // R3
  AST_WR_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wr_rel_o) |-> $past(rd_rel_o) == '0); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_rel_o && !wr_go_i |=> wr_rel_o && $stable(data_o)); // R9
  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_rel_o && wr_go_i |=> !wr_rel_o && !busy_o); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> !busy_o && !wr_rel_o && rd_rel_o == '0); // R1
endmodule

// File: tb/tb_cu_unit.sv
`timescale 1ns/1ps
module tb_cu_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [3:0]  op_i;
  logic        inv_a_i, zero_a_i, imm_ok_i;
  logic [15:0] imm_i;
  logic [1:0]  rd_mask_i;
  logic [15:0] src_a_i, src_b_i;
  logic [1:0]  rd_rel_o;
  logic [1:0]  rd_go_i;
  logic        wr_rel_o;
  logic        wr_go_i;
  logic [15:0] data_o;
  logic        busy_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  cu_unit dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .inv_a_i(inv_a_i), .zero_a_i(zero_a_i), .imm_ok_i(imm_ok_i),
    .imm_i(imm_i), .rd_mask_i(rd_mask_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .rd_rel_o(rd_rel_o), .rd_go_i(rd_go_i),
    .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i), .data_o(data_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string msg,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [3:0] op, input bit inv,
      input bit zr, input bit immk, input logic [15:0] imm,
      input logic [1:0] mask, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] ea, eb;
    ea = (zr || mask[0]) ? 16'd0 : a;
    eb = immk ? imm : (mask[1] ? 16'd0 : b);
    if (op == 4'd1) return (inv ? ~ea : ea) + eb;
    return ea - eb;
  endfunction

  task automatic run_op(input logic [3:0] op, input bit inv, input bit zr,
      input bit immk, input logic [15:0] imm, input logic [1:0] mask,
      input logic [15:0] a, input logic [15:0] b,
      input int da, input int db, input int dw, input string tag);
    logic [15:0] exp;
    bit need [2];
    bit pend [2];
    int wt [2];
    exp = model(op, inv, zr, immk, imm, mask, a, b);
    need[0] = !(zr || mask[0]);
    need[1] = !(immk || mask[1]);
    chk(busy_o == 1'b0, "R2 busy low at issue", busy_o, 0);
    issue_i = 1'b1; op_i = op; inv_a_i = inv; zero_a_i = zr;
    imm_ok_i = immk; imm_i = imm; rd_mask_i = mask;
    @(posedge clk); #1;
    // R10: scramble fields after issue; latched values must be used
    issue_i = 1'b0; op_i = ~op; inv_a_i = ~inv; zero_a_i = ~zr;
    imm_ok_i = ~immk; imm_i = ~imm;
    chk(busy_o == 1'b1, "R2 busy after issue", busy_o, 1);
    chk(rd_rel_o == {need[1], need[0]}, "R3/R5 read requests after issue",
        rd_rel_o, {need[1], need[0]});
    pend[0] = need[0]; pend[1] = need[1];
    wt[0] = da; wt[1] = db;
    while (pend[0] || pend[1]) begin
      for (int p = 0; p < 2; p++) begin
        if (pend[p]) begin
          chk(rd_rel_o[p] == 1'b1, "R3 request held until go", rd_rel_o[p], 1);
          if (wt[p] == 0) begin
            rd_go_i[p] = 1'b1;
            if (p == 0) src_a_i = a; else src_b_i = b;
            pend[p] = 1'b0;
          end else wt[p]--;
        end else begin
          chk(rd_rel_o[p] == 1'b0, "R4 request low after go or skip", rd_rel_o[p], 0);
        end
      end
      @(posedge clk); #1;
      rd_go_i = 2'b00; src_a_i = 16'hDEAD; src_b_i = 16'hBEEF;
    end
    chk(rd_rel_o == 2'b00, "R4 requests dropped", rd_rel_o, 0);
    chk(wr_rel_o == 1'b0, "R9 write request not yet", wr_rel_o, 0);
    @(posedge clk); #1;
    chk(wr_rel_o == 1'b1, "R9 write request raised", wr_rel_o, 1);
    chk(data_o == exp, {"R6/R7/R8 result ", tag}, data_o, exp);
    for (int i = 0; i < dw; i++) begin
      if (i == dw / 2) begin
        issue_i = 1'b1; op_i = 4'd1; inv_a_i = 1'b1; zero_a_i = 1'b0;
      end
      @(posedge clk); #1;
      issue_i = 1'b0;
      chk(busy_o && wr_rel_o, "R2 busy and write request held, stray issue ignored",
          {busy_o, wr_rel_o}, 3);
      chk(data_o == exp, "R9 data stable while write request", data_o, exp);
      chk(rd_rel_o == 2'b00, "R2 stray issue raised no read", rd_rel_o, 0);
    end
    wr_go_i = 1'b1;
    @(posedge clk); #1;
    wr_go_i = 1'b0;
    chk(!busy_o && !wr_rel_o, "R10 write go clears busy", {busy_o, wr_rel_o}, 0);
    @(posedge clk); #1;
    chk(!busy_o, "R2 busy does not rise alone", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] r_op;
    rst_n = 1'b0; issue_i = 1'b0; op_i = '0; inv_a_i = 0; zero_a_i = 0;
    imm_ok_i = 0; imm_i = '0; rd_mask_i = '0; src_a_i = '0; src_b_i = '0;
    rd_go_i = '0; wr_go_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!busy_o && rd_rel_o == 0 && !wr_rel_o, "R1 reset outputs quiet",
        {busy_o, rd_rel_o, wr_rel_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(!busy_o, "R2 idle after reset", busy_o, 0);

    run_op(4'd1, 0, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 0, 1, "R7 add 5+2");
    run_op(4'd1, 1, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 0, 3, 2, "R7 inverted add");
    run_op(4'd1, 0, 1, 0, 16'd0, 2'b00, 16'd5, 16'd2, 2, 0, 1, "R6 zero A");
    run_op(4'd1, 0, 0, 1, 16'd9, 2'b00, 16'd5, 16'd2, 0, 0, 1, "R6 immediate B");
    run_op(4'd1, 0, 1, 1, 16'd4, 2'b00, 16'd5, 16'd2, 0, 0, 2, "R5 no reads");
    run_op(4'd0, 0, 0, 0, 16'd0, 2'b00, 16'd5, 16'd2, 3, 1, 1, "R8 subtract");
    run_op(4'd7, 0, 0, 0, 16'd0, 2'b00, 16'd2, 16'd5, 1, 1, 1, "R8 subtract wraps");
    run_op(4'd1, 0, 0, 0, 16'd0, 2'b11, 16'd5, 16'd2, 0, 0, 1, "R5 both masked");
    run_op(4'd1, 0, 0, 0, 16'd0, 2'b01, 16'd5, 16'd2, 0, 2, 1, "R5 mask A");
    run_op(4'd1, 0, 0, 0, 16'd0, 2'b10, 16'hFFFF, 16'd2, 2, 0, 1, "R5 mask B");

    void'($urandom(32'd12345));
    for (int k = 0; k < 40; k++) begin
      r_op = ($urandom % 3 == 0) ? 4'($urandom) : 4'd1;
      run_op(r_op, 1'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
             16'($urandom), (($urandom % 3) == 0) ? 2'($urandom) : 2'b00,
             16'($urandom), 16'($urandom),
             int'($urandom % 4), int'($urandom % 4), 1 + int'($urandom % 3),
             "R7/R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule